// File: doc/BRIEF.md
# DAC Sample Buffer Controller

This block keeps a small table of converter codes in front of a DAC and steps through it on a hardware trigger. The word under the read pointer is always driven on `dac_o`, so every trigger that moves the pointer presents a new code to the converter. A processor or a DMA engine loads words through a single write port. An 8-bit status word reports three sticky flags: watermark, top and bottom. Software clears a flag by writing a zero to it. When DMA is enabled, a completed DMA transfer clears the flags.

The block has two modes, chosen by `fifo_mode_i`. In ring mode (0), the table is addressed directly and the read pointer cycles from zero up to a programmable last index. In queue mode (1), writes are appended at a tail pointer and triggers consume words from the head. In queue mode the three flags take new meanings: watermark, nearly empty and full. Triggers are refused while one word or fewer is left, so the output holds its last code and does not jump. Flags are set only on the cycle in which the buffer state changes. A change of mode re-initialises the pointers and the status.

Top module: `dacbuf_ctrl`

## Requirements
- R1: After reset, `stat_o` reads 0x02, `dac_o` is 0 and `dma_req_o` is 0. Status bit 2 is the watermark flag, bit 1 the top flag, bit 0 the bottom flag, and bits 7..3 always read 0.
- R2: In ring mode a trigger moves the read pointer up by one, and from the last index (`upper_idx_i`) or beyond it moves to 0. `dac_o` shows the stored word at the read pointer. A ring-mode write stores `wr_data_i` at `wr_idx_i`.
- R3: In ring mode the top flag sets when a trigger moves the pointer to 0 from another index, and the bottom flag sets when a trigger moves it onto `upper_idx_i` from another index. A trigger that leaves the pointer where it was sets neither flag.
- R4: The watermark threshold is `wm_sel_i`+1 words. In ring mode the words left are `upper_idx_i` minus the read pointer, or 0 when the pointer is at or past the last index. The watermark flag sets on the trigger that takes this count from at or above the threshold to below it.
- R5: A status write clears each flag whose `stat_clr_n_i` bit is 0 and leaves the flags whose bit is 1 unchanged. In ring mode all three flags are clearable. In queue mode only the top flag is.
- R6: When a hardware set of a flag and a software clear of that flag fall in the same cycle, the flag ends up set.
- R7: `dma_req_o` equals `dma_en_i` AND (watermark flag OR top flag). A `dma_done_i` pulse while `dma_en_i` is 1 clears the flags that are clearable in the current mode.
- R8: In queue mode an accepted write appends at the tail. A trigger that advances the head makes `dac_o` show the next word in write order.
- R9: In queue mode the top flag means nearly empty. It sets when the word count becomes 1 and clears by itself when the count goes above 1. A trigger with a count of 1 or less does not move the head, so `dac_o` holds.
- R10: In queue mode the bottom flag means full. It sets when a write brings the count to 16. While it is set, writes are dropped and software cannot clear it. It clears when a trigger advances the head.
- R11: In queue mode the watermark flag sets on the trigger that takes the count below the threshold. It clears when a write is accepted, and software writes do not clear it.
- R12: One cycle after `fifo_mode_i` changes, the pointers and the count are 0 and `stat_o` is 0x02. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_mode_i | input | 1 | 0 ring mode, 1 queue mode |
| upper_idx_i | input | 4 | Last index of the ring |
| wm_sel_i | input | 2 | Watermark threshold minus one |
| wr_valid_i | input | 1 | Write strobe from CPU or DMA |
| wr_idx_i | input | 4 | Write index in ring mode |
| wr_data_i | input | 12 | Word to store |
| trig_i | input | 1 | Hardware trigger |
| stat_we_i | input | 1 | Status write strobe |
| stat_clr_n_i | input | 3 | Status write data, 0 clears the flag |
| dma_en_i | input | 1 | DMA enable |
| dma_done_i | input | 1 | DMA transfer completed |
| dac_o | output | 12 | Code to the converter |
| stat_o | output | 8 | Status word |
| dma_req_o | output | 1 | DMA request |

## Verification
A wrong read pointer shows on `dac_o` in the cycle after the trigger, because the output is the stored word under the pointer, read with no register in between. A wrong queue count stays hidden until a later boundary. It shows as a nearly-empty or full flag that appears one push or pop early or late, as a refused trigger, or as a dropped write that corrupts the head word. The directed scenarios therefore walk each count through its boundaries and read both the status word and the output code at every step. A missed or repeated edge-event set shows one cycle after the causing trigger or write, because flags are written only on those events.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

  typedef enum logic {
    MODE_RING = 1'b0,
    MODE_FIFO = 1'b1
  } buf_mode_e;

  // Status bit positions, decoded by software
  localparam int FLG_BOT = 0;
  localparam int FLG_TOP = 1;
  localparam int FLG_WM  = 2;
  localparam int NFLG    = 3;

  localparam logic [NFLG-1:0] FLAGS_RESET = 3'b010;

  // Watermark threshold in words
  function automatic logic [2:0] wm_words(input logic [1:0] sel);
    return {1'b0, sel} + 3'd1;
  endfunction

endpackage

// File: rtl/dacbuf_store.sv
module dacbuf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [DW-1:0] row_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (we_i && (waddr_i == AW'(g))) begin
        row_q <= wdata_i;
      end
    end
    assign rows[g] = row_q;
  end

  assign rdata_o = rows[raddr_i];

endmodule

// File: rtl/dacbuf_ptrs.sv
module dacbuf_ptrs
  import dacbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fifo_i,
  input  logic            reinit_i,
  input  logic [AW-1:0]   upper_i,
  input  logic [1:0]      wm_sel_i,
  input  logic            wr_valid_i,
  input  logic [AW-1:0]   wr_idx_i,
  input  logic            trig_i,
  input  logic            full_flag_i,
  output logic [AW-1:0]   rd_ptr_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            wr_en_o,
  output logic [NFLG-1:0] set_ev_o,
  output logic [NFLG-1:0] hwclr_ev_o
);

  function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] p,
                                              input logic [AW-1:0] lim);
    return (p >= lim) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] fifo_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ring_left(input logic [AW-1:0] p,
                                              input logic [AW-1:0] lim);
    return (p >= lim) ? '0 : lim - p;
  endfunction

  function automatic logic below_wm(input logic [CW-1:0] n,
                                    input logic [1:0] sel);
    return n < CW'(wm_words(sel));
  endfunction

  logic [AW-1:0] rd_q, wr_q, rd_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          adv_ev;   // head/pointer moves this cycle
  logic          wr_acc;   // write accepted this cycle

  always_comb begin
    adv_ev     = 1'b0;
    wr_acc     = 1'b0;
    rd_nx      = rd_q;
    cnt_nx     = cnt_q;
    set_ev_o   = '0;
    hwclr_ev_o = '0;
    wr_addr_o  = wr_idx_i;
    if (!reinit_i) begin
      if (fifo_i) begin
        wr_addr_o = wr_q;
        wr_acc    = wr_valid_i && !full_flag_i;
        adv_ev    = trig_i && (cnt_q >= CW'(2));
        if (adv_ev) rd_nx = fifo_next(rd_q);
        cnt_nx = cnt_q + CW'(wr_acc) - CW'(adv_ev);
        set_ev_o[FLG_TOP]   = (cnt_nx == CW'(1)) && (cnt_q != CW'(1));
        hwclr_ev_o[FLG_TOP] = cnt_nx > CW'(1);
        set_ev_o[FLG_BOT]   = wr_acc && !adv_ev && (cnt_nx == CW'(DEPTH));
        hwclr_ev_o[FLG_BOT] = adv_ev;
        set_ev_o[FLG_WM]    = adv_ev && !wr_acc && !below_wm(cnt_q, wm_sel_i)
                              && below_wm(cnt_nx, wm_sel_i);
        hwclr_ev_o[FLG_WM]  = wr_acc;
      end else begin
        wr_acc = wr_valid_i;
        adv_ev = trig_i;
        if (adv_ev) rd_nx = ring_next(rd_q, upper_i);
        set_ev_o[FLG_TOP] = adv_ev && (rd_nx == '0) && (rd_q != '0);
        set_ev_o[FLG_BOT] = adv_ev && (rd_nx == upper_i) && (rd_q != upper_i);
        set_ev_o[FLG_WM]  = adv_ev
                            && !below_wm(CW'(ring_left(rd_q, upper_i)), wm_sel_i)
                            && below_wm(CW'(ring_left(rd_nx, upper_i)), wm_sel_i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || reinit_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_nx;
      cnt_q <= cnt_nx;
      if (fifo_i && wr_acc) wr_q <= fifo_next(wr_q);
    end
  end

  assign rd_ptr_o = rd_q;
  assign wr_en_o  = wr_acc;

  // R9: a trigger with one word or none left leaves the head in place
  p_stall_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_i && !reinit_i && trig_i && cnt_q <= CW'(1)) |=> $stable(rd_q));

  // R10: the queue never holds more than its depth
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R10: a write while full changes nothing
  p_drop_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_i && !reinit_i && full_flag_i && wr_valid_i && !trig_i)
      |=> ($stable(cnt_q) && $stable(wr_q)));

  // R2: leaving the last ring index lands on zero
  p_ring_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_i && !reinit_i && trig_i && rd_q == upper_i) |=> (rd_q == '0));

endmodule

// File: rtl/dacbuf_flags.sv
module dacbuf_flags
  import dacbuf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reinit_i,
  input  logic            fifo_i,
  input  logic [NFLG-1:0] set_ev_i,
  input  logic [NFLG-1:0] hwclr_ev_i,
  input  logic            sw_we_i,
  input  logic [NFLG-1:0] sw_clr_n_i,
  input  logic            dma_en_i,
  input  logic            dma_done_i,
  output logic [NFLG-1:0] flags_o
);

  logic [NFLG-1:0] clr_mask;
  logic [NFLG-1:0] sw_clr_ev;

  // Queue mode: only the nearly-empty flag yields to software
  assign clr_mask  = fifo_i ? (NFLG'(1) << FLG_TOP) : '1;
  assign sw_clr_ev = (({NFLG{sw_we_i}} & ~sw_clr_n_i) |
                      {NFLG{dma_en_i && dma_done_i}}) & clr_mask;

  for (genvar i = 0; i < NFLG; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni || reinit_i) begin
        bit_q <= FLAGS_RESET[i];
      end else if (set_ev_i[i]) begin
        bit_q <= 1'b1;
      end else if (hwclr_ev_i[i] || sw_clr_ev[i]) begin
        bit_q <= 1'b0;
      end
    end
    assign flags_o[i] = bit_q;

    // R6: a hardware set always lands, whatever else happens that cycle
    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_ev_i[i] |=> flags_o[i]);
  end

  // R10: the full flag holds until a head advance clears it
  p_full_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_i && !reinit_i && flags_o[FLG_BOT] && !hwclr_ev_i[FLG_BOT])
      |=> flags_o[FLG_BOT]);

  // R7: DMA completion in ring mode empties the status
  p_dma_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_i && !reinit_i && dma_en_i && dma_done_i && set_ev_i == '0)
      |=> (flags_o == '0));

endmodule

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int DW    = 12,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_mode_i,
  input  logic [AW-1:0] upper_idx_i,
  input  logic [1:0]    wm_sel_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          trig_i,
  input  logic          stat_we_i,
  input  logic [2:0]    stat_clr_n_i,
  input  logic          dma_en_i,
  input  logic          dma_done_i,
  output logic [DW-1:0] dac_o,
  output logic [7:0]    stat_o,
  output logic          dma_req_o
);

  localparam int CW = $clog2(DEPTH + 1);

  buf_mode_e       mode_q;
  logic            reinit;
  logic            fifo_on;
  logic [AW-1:0]   rd_ptr, wr_addr;
  logic            wr_en;
  logic [NFLG-1:0] set_ev, hwclr_ev, flags;

  assign fifo_on = (mode_q == MODE_FIFO);
  assign reinit  = (buf_mode_e'(fifo_mode_i) != mode_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= MODE_RING;
    else         mode_q <= buf_mode_e'(fifo_mode_i);
  end

  dacbuf_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_i      (fifo_on),
    .reinit_i    (reinit),
    .upper_i     (upper_idx_i),
    .wm_sel_i    (wm_sel_i),
    .wr_valid_i  (wr_valid_i),
    .wr_idx_i    (wr_idx_i),
    .trig_i      (trig_i),
    .full_flag_i (flags[FLG_BOT]),
    .rd_ptr_o    (rd_ptr),
    .wr_addr_o   (wr_addr),
    .wr_en_o     (wr_en),
    .set_ev_o    (set_ev),
    .hwclr_ev_o  (hwclr_ev)
  );

  dacbuf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (dac_o)
  );

  dacbuf_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reinit_i   (reinit),
    .fifo_i     (fifo_on),
    .set_ev_i   (set_ev),
    .hwclr_ev_i (hwclr_ev),
    .sw_we_i    (stat_we_i),
    .sw_clr_n_i (stat_clr_n_i),
    .dma_en_i   (dma_en_i),
    .dma_done_i (dma_done_i),
    .flags_o    (flags)
  );

  assign stat_o    = {5'b0, flags};
  assign dma_req_o = dma_en_i && (flags[FLG_WM] || flags[FLG_TOP]);

  // R12: a mode change brings the status back to its reset value
  p_reinit_stat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit |=> (stat_o == 8'h02));

endmodule

// File: tb/dacbuf_ctrl_tb_top.sv
module dacbuf_ctrl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_mode_i = 1'b0;
  logic [3:0]  upper_idx_i = '0;
  logic [1:0]  wm_sel_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [11:0] wr_data_i = '0;
  logic        trig_i = 1'b0;
  logic        stat_we_i = 1'b0;
  logic [2:0]  stat_clr_n_i = '1;
  logic        dma_en_i = 1'b0;
  logic        dma_done_i = 1'b0;
  logic [11:0] dac_o;
  logic [7:0]  stat_o;
  logic        dma_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  dacbuf_ctrl dut_i (
    .clk_i, .rst_ni, .fifo_mode_i, .upper_idx_i, .wm_sel_i, .wr_valid_i,
    .wr_idx_i, .wr_data_i, .trig_i, .stat_we_i, .stat_clr_n_i, .dma_en_i,
    .dma_done_i, .dac_o, .stat_o, .dma_req_o
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic ring_write(input logic [3:0] idx, input logic [11:0] d);
    wr_valid_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    tick();
    wr_valid_i = 1'b0;
  endtask

  task automatic push(input logic [11:0] d);
    wr_valid_i = 1'b1; wr_data_i = d;
    tick();
    wr_valid_i = 1'b0;
  endtask

  task automatic trig_n(input int n);
    for (int k = 0; k < n; k++) begin
      trig_i = 1'b1;
      tick();
      trig_i = 1'b0;
    end
  endtask

  task automatic sw_write(input logic [2:0] v);
    stat_we_i = 1'b1; stat_clr_n_i = v;
    tick();
    stat_we_i = 1'b0; stat_clr_n_i = '1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1", "status after reset", 16'(stat_o), 16'h02);
    chk("R1", "dac after reset", 16'(dac_o), 16'h000);
    chk("R1", "dma request after reset", 16'(dma_req_o), 16'h0);
  endtask

  task automatic t_ring_walk();
    upper_idx_i = 4'd3; wm_sel_i = 2'd0;
    for (int i = 0; i < 4; i++) ring_write(4'(i), 12'(12'h100 + i));
    sw_write(3'b000);
    chk("R5", "all cleared", 16'(stat_o), 16'h00);
    chk("R2", "dac at index 0", 16'(dac_o), 16'h100);
    trig_n(1);
    chk("R2", "dac at index 1", 16'(dac_o), 16'h101);
    chk("R3", "no flag mid ring", 16'(stat_o), 16'h00);
    trig_n(2);
    chk("R3", "bottom and watermark at last index", 16'(stat_o), 16'h05);
    chk("R2", "dac at index 3", 16'(dac_o), 16'h103);
    trig_n(1);
    chk("R2", "wrap to index 0", 16'(dac_o), 16'h100);
    chk("R3", "top set on wrap", 16'(stat_o), 16'h07);
  endtask

  task automatic t_sw_clear();
    sw_write(3'b110);
    chk("R5", "write 0 clears bottom only", 16'(stat_o), 16'h06);
    sw_write(3'b111);
    chk("R5", "write 1 keeps flags", 16'(stat_o), 16'h06);
    sw_write(3'b000);
    chk("R5", "write 0 clears rest", 16'(stat_o), 16'h00);
  endtask

  task automatic t_set_priority();
    trig_n(2);
    trig_i = 1'b1; stat_we_i = 1'b1; stat_clr_n_i = 3'b000;
    tick();
    trig_i = 1'b0; stat_we_i = 1'b0; stat_clr_n_i = '1;
    chk("R6", "set beats same-cycle clear", 16'(stat_o), 16'h05);
  endtask

  task automatic t_no_change();
    upper_idx_i = 4'd0;
    sw_write(3'b000);
    trig_n(1);
    chk("R3", "move from 3 to 0 with last index 0", 16'(stat_o), 16'h03);
    sw_write(3'b000);
    trig_n(1);
    chk("R3", "pointer unchanged sets nothing", 16'(stat_o), 16'h00);
    chk("R2", "dac holds index 0", 16'(dac_o), 16'h100);
  endtask

  task automatic t_ring_wm();
    upper_idx_i = 4'd7; wm_sel_i = 2'd1;
    trig_n(5);
    chk("R4", "two left, no watermark", 16'(stat_o), 16'h00);
    trig_n(1);
    chk("R4", "one left, watermark", 16'(stat_o), 16'h04);
  endtask

  task automatic t_dma();
    chk("R7", "no request while disabled", 16'(dma_req_o), 16'h0);
    dma_en_i = 1'b1;
    @(negedge clk_i);
    chk("R7", "request on watermark", 16'(dma_req_o), 16'h1);
    dma_done_i = 1'b1;
    tick();
    dma_done_i = 1'b0;
    chk("R7", "done clears flags", 16'(stat_o), 16'h00);
    chk("R7", "request drops", 16'(dma_req_o), 16'h0);
    dma_en_i = 1'b0;
  endtask

  task automatic t_mode_switch();
    fifo_mode_i = 1'b1;
    tick();
    chk("R12", "status after mode change", 16'(stat_o), 16'h02);
    chk("R12", "head at 0, words kept", 16'(dac_o), 16'h100);
  endtask

  task automatic t_fifo_basic();
    wm_sel_i = 2'd0;
    push(12'hA01);
    chk("R9", "one word, nearly empty", 16'(stat_o), 16'h02);
    chk("R8", "head word", 16'(dac_o), 16'hA01);
    trig_n(1);
    chk("R9", "trigger refused at one word", 16'(dac_o), 16'hA01);
    push(12'hA02);
    chk("R9", "two words clear nearly empty", 16'(stat_o), 16'h00);
    trig_n(1);
    chk("R8", "pop shows next word", 16'(dac_o), 16'hA02);
    chk("R9", "back to one word", 16'(stat_o), 16'h02);
    trig_n(1);
    chk("R9", "output holds", 16'(dac_o), 16'hA02);
    sw_write(3'b000);
    chk("R5", "nearly empty clearable in queue mode", 16'(stat_o), 16'h00);
  endtask

  task automatic t_fifo_full();
    for (int i = 0; i < 14; i++) push(12'(12'hB00 + i));
    chk("R10", "fifteen words, not full", 16'(stat_o), 16'h00);
    push(12'hB0E);
    chk("R10", "sixteen words, full", 16'(stat_o), 16'h01);
    push(12'hEEE);
    chk("R10", "dropped write keeps head", 16'(dac_o), 16'hA02);
    sw_write(3'b000);
    chk("R10", "software cannot clear full", 16'(stat_o), 16'h01);
    trig_n(1);
    chk("R10", "pop clears full", 16'(stat_o), 16'h00);
    chk("R8", "next word after pop", 16'(dac_o), 16'hB00);
  endtask

  task automatic t_fifo_wm();
    wm_sel_i = 2'd3;
    trig_n(11);
    chk("R11", "four words left", 16'(stat_o), 16'h00);
    trig_n(1);
    chk("R11", "three words left, watermark", 16'(stat_o), 16'h04);
    chk("R8", "head after twelve pops", 16'(dac_o), 16'hB0C);
    sw_write(3'b000);
    chk("R11", "software cannot clear watermark", 16'(stat_o), 16'h04);
    push(12'hC00);
    chk("R11", "write clears watermark", 16'(stat_o), 16'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ring_walk();
    t_sw_clear();
    t_set_priority();
    t_no_change();
    t_ring_wm();
    t_dma();
    t_mode_switch();
    t_fifo_basic();
    t_fifo_full();
    t_fifo_wm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule